// File: doc/BRIEF.md
# Decode-Stage Branch Resolver

This block settles conditional branches while the branch is still in the decode stage of a five-stage in-order pipeline. It has its own equality comparator and its own target adder, so the next-PC choice is ready before the end of the decode cycle. The fetch PC register takes that choice on the following clock edge. A taken branch therefore costs one cycle. A three-cycle penalty would follow if the outcome waited for the execute-stage ALU and the memory-stage register.

The architecture defines exactly one delay slot. The instruction fetched right after a branch always runs to completion, taken or not, so the block has no squash or flush output. The block holds no state. Every output is a function of the instruction in decode during the current cycle. Two branches in a row (a branch placed in the delay slot of another) are each resolved in their own decode cycle, using their own operands and their own incremented PC.

The decode stage supplies the two register operands already resolved. Fetch, the register file and any bypass into the comparator sit outside this block. All pins are plain control and data pins, with no streaming handshake. There is no back-pressure because the block produces one decision per decode cycle and stores nothing.

Top module: `brres_unit`

## Requirements
- R1: When `inst_valid` is 1 and `opcode` is 6'h14 (branch-on-equal), `br_taken` is 1 exactly when `rs_val` equals `rt_val`.
- R2: When `inst_valid` is 1 and `opcode` is 6'h15 (branch-on-not-equal), `br_taken` is 1 exactly when `rs_val` differs from `rt_val`.
- R3: For every other opcode, and whenever `inst_valid` is 0, `br_taken` is 0, `pc_sel` is 0 and `next_pc` equals `pc_plus4`, whatever the operand values.
- R4: `br_target` equals `pc_plus4` plus the 16-bit `imm` sign-extended to 32 bits and shifted left by two, modulo 2^32. This holds for negative offsets and for every opcode.
- R5: `pc_sel` is 1 (select target) exactly when `br_taken` is 1. `next_pc` is `br_target` when `pc_sel` is 1 and `pc_plus4` when it is 0.
- R6: The outputs depend only on the inputs of the current cycle. A branch in the delay slot of an earlier branch is resolved from its own fields, with no influence from the earlier decision.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| inst_valid | input | 1 | Decode stage holds a real instruction (0 = bubble) |
| opcode | input | 6 | Major opcode of the decode-stage instruction |
| imm | input | 16 | Immediate field, a signed word displacement |
| rs_val | input | 32 | First register operand |
| rt_val | input | 32 | Second register operand |
| pc_plus4 | input | 32 | Address of the branch plus four |
| br_taken | output | 1 | Branch condition met |
| br_target | output | 32 | Computed branch target address |
| pc_sel | output | 1 | Next-PC select: 0 sequential, 1 target |
| next_pc | output | 32 | Address the fetch PC loads on the next edge |

## Verification
The assertions assume the decode stage presents settled, fully resolved operands before they are checked. They also assume `pc_plus4` and `imm` are defined values, because the target check works back from the output to the offset by subtraction. The bench holds `inst_valid` low during reset. It drives a new input set once per cycle at the falling edge and lets the combinational outputs settle before it samples them. Random operand pairs are forced equal about half the time so that both comparator outcomes occur, and offsets cover both signs and the extreme values.

// File: rtl/brres_pkg.sv
package brres_pkg;
  localparam int OP_W = 6;
  localparam logic [OP_W-1:0] OP_BR_EQ = 6'h14;
  localparam logic [OP_W-1:0] OP_BR_NE = 6'h15;

  typedef enum logic {
    SEL_SEQ = 1'b0,
    SEL_TGT = 1'b1
  } npc_sel_e;

  typedef struct packed {
    logic is_br;
    logic want_eq;
  } br_kind_t;
endpackage

// File: rtl/brres_decode.sv
module brres_decode
  import brres_pkg::*;
(
  input  logic            inst_valid,
  input  logic [OP_W-1:0] opcode,
  output br_kind_t        kind
);
  always_comb begin
    kind = '0;
    if (inst_valid) begin
      unique case (opcode)
        OP_BR_EQ: begin
          kind.is_br   = 1'b1;
          kind.want_eq = 1'b1;
        end
        OP_BR_NE: begin
          kind.is_br   = 1'b1;
          kind.want_eq = 1'b0;
        end
        default: kind = '0;
      endcase
    end
  end
endmodule

// File: rtl/brres_cmp.sv
module brres_cmp #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic              equal
);
  localparam int LANES = DATA_W / LANE_W;
  logic [LANES-1:0] lane_eq;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_eq[g] = (a[g*LANE_W +: LANE_W] == b[g*LANE_W +: LANE_W]);
  end

  assign equal = &lane_eq;
endmodule

// File: rtl/brres_tgt.sv
module brres_tgt #(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [IMM_W-1:0]  disp,
  output logic [ADDR_W-1:0] target
);
  localparam int EXT_W = ADDR_W - IMM_W - 2;
  logic [ADDR_W-1:0] byte_off;

  assign byte_off = {{EXT_W{disp[IMM_W-1]}}, disp, 2'b00};
  assign target   = base + byte_off;
endmodule

// File: rtl/brres_unit.sv
module brres_unit
  import brres_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int LANE_W = 8
) (
  input  logic              inst_valid,
  input  logic [OP_W-1:0]   opcode,
  input  logic [IMM_W-1:0]  imm,
  input  logic [DATA_W-1:0] rs_val,
  input  logic [DATA_W-1:0] rt_val,
  input  logic [ADDR_W-1:0] pc_plus4,
  output logic              br_taken,
  output logic [ADDR_W-1:0] br_target,
  output logic              pc_sel,
  output logic [ADDR_W-1:0] next_pc
);
  br_kind_t kind;
  logic     ops_equal;
  npc_sel_e sel;

  brres_decode u_dec (
    .inst_valid (inst_valid),
    .opcode     (opcode),
    .kind       (kind)
  );

  brres_cmp #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_cmp (
    .a     (rs_val),
    .b     (rt_val),
    .equal (ops_equal)
  );

  brres_tgt #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_tgt (
    .base   (pc_plus4),
    .disp   (imm),
    .target (br_target)
  );

  assign br_taken = kind.is_br & (kind.want_eq ? ops_equal : ~ops_equal);
  assign sel      = br_taken ? SEL_TGT : SEL_SEQ;
  assign pc_sel   = sel;

  always_comb begin
    unique case (sel)
      SEL_TGT: next_pc = br_target;
      default: next_pc = pc_plus4;
    endcase
  end
endmodule

// File: rtl/brres_chk.sv
module brres_chk
  import brres_pkg::*;
(
  input logic        inst_valid,
  input logic [5:0]  opcode,
  input logic [15:0] imm,
  input logic [31:0] rs_val,
  input logic [31:0] rt_val,
  input logic [31:0] pc_plus4,
  input logic        br_taken,
  input logic [31:0] br_target,
  input logic        pc_sel,
  input logic [31:0] next_pc
);
  logic [31:0]        gap;
  logic signed [31:0] gap_words;

  always_comb begin
    gap       = br_target - pc_plus4;
    gap_words = $signed(gap) >>> 2;
    AST_EQ_COND: assert (!(br_taken && opcode == OP_BR_EQ) || rs_val == rt_val); // R1
    AST_NE_COND: assert (!(br_taken && opcode == OP_BR_NE) || rs_val != rt_val); // R2
    AST_NO_TAKE_OTHER: assert (br_taken == 1'b0 || (inst_valid && (opcode == OP_BR_EQ || opcode == OP_BR_NE))); // R3
    AST_TGT_ALIGN: assert (gap[1:0] == 2'b00); // R4
    AST_TGT_OFFSET: assert (gap_words == 32'($signed(imm))); // R4
    AST_SEL_TRACK: assert (pc_sel == br_taken); // R5
    AST_NEXT_SRC: assert (next_pc == (pc_sel ? br_target : pc_plus4)); // R5
  end
endmodule

bind brres_unit brres_chk u_chk (
  .inst_valid (inst_valid),
  .opcode     (opcode),
  .imm        (imm),
  .rs_val     (rs_val),
  .rt_val     (rt_val),
  .pc_plus4   (pc_plus4),
  .br_taken   (br_taken),
  .br_target  (br_target),
  .pc_sel     (pc_sel),
  .next_pc    (next_pc)
);

// File: tb/tb_brres_unit.sv
`timescale 1ns/1ps
module tb_brres_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inst_valid;
  logic [5:0]  opcode;
  logic [15:0] imm;
  logic [31:0] rs_val, rt_val, pc_plus4;
  logic        br_taken, pc_sel;
  logic [31:0] br_target, next_pc;
  int          n_chk = 0;
  int          n_fail = 0;

  always #4 clk = ~clk;

  brres_unit dut (
    .inst_valid (inst_valid), .opcode (opcode), .imm (imm),
    .rs_val (rs_val), .rt_val (rt_val), .pc_plus4 (pc_plus4),
    .br_taken (br_taken), .br_target (br_target),
    .pc_sel (pc_sel), .next_pc (next_pc)
  );

  function automatic logic [31:0] f_target(input logic [31:0] pc4, input logic [15:0] d);
    int signed words;
    words = int'($signed(d));
    return pc4 + 32'(words * 4);
  endfunction

  function automatic logic f_taken(input logic v, input logic [5:0] op,
                                   input logic [31:0] a, input logic [31:0] b);
    if (!v) return 1'b0;
    if (op == 6'h14) return a == b;
    if (op == 6'h15) return a != b;
    return 1'b0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [5:0] op, input logic [15:0] d,
                       input logic [31:0] a, input logic [31:0] b, input logic [31:0] pc4);
    @(negedge clk);
    inst_valid = v; opcode = op; imm = d; rs_val = a; rt_val = b; pc_plus4 = pc4;
    #1;
  endtask

  task automatic check_all(input string tag);
    logic t;
    t = f_taken(inst_valid, opcode, rs_val, rt_val);
    chk({tag, " taken"}, {31'd0, br_taken}, {31'd0, t});
    chk("R4 target", br_target, f_target(pc_plus4, imm));
    chk("R5 sel", {31'd0, pc_sel}, {31'd0, t});
    chk("R5 next_pc", next_pc, t ? f_target(pc_plus4, imm) : pc_plus4);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] a;
    logic [31:0] b;
    logic [5:0]  op;
    logic [31:0] seed;
    seed = $urandom(32'h5EED_0B17);
    inst_valid = 1'b0; opcode = 6'h14; imm = 16'h0004;
    rs_val = 32'h0; rt_val = 32'h0; pc_plus4 = 32'h0000_1004;
    repeat (3) @(posedge clk);
    #1;
    // R3: bubble during reset never redirects, even with equal operands
    chk("R3 reset taken", {31'd0, br_taken}, 32'd0);
    chk("R3 reset next_pc", next_pc, 32'h0000_1004);
    rst_n = 1'b1;

    // R1 directed equal and unequal
    drive(1, 6'h14, 16'h0010, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 32'h0000_2000);
    check_all("R1");
    chk("R1 target", next_pc, 32'h0000_2040);
    drive(1, 6'h14, 16'h0010, 32'hDEAD_BEEF, 32'hDEAD_BEEE, 32'h0000_2000);
    check_all("R1");
    // R2 directed
    drive(1, 6'h15, 16'h0001, 32'h1, 32'h8000_0001, 32'h0000_3000);
    check_all("R2");
    chk("R2 next_pc", next_pc, 32'h0000_3004);
    drive(1, 6'h15, 16'h0001, 32'h7, 32'h7, 32'h0000_3000);
    check_all("R2");
    // R4 negative and extreme offsets
    drive(1, 6'h14, 16'hFFFF, 32'h5, 32'h5, 32'h0000_1000);
    chk("R4 minus one word", br_target, 32'h0000_0FFC);
    drive(1, 6'h14, 16'h8000, 32'h5, 32'h5, 32'h0001_0000);
    chk("R4 most negative", br_target, 32'hFFFF_0000);
    drive(0, 6'h00, 16'hFFFE, 32'h5, 32'h6, 32'h0000_0004);
    chk("R4 wrap below zero", br_target, 32'hFFFF_FFFC);
    drive(1, 6'h15, 16'h7FFF, 32'h5, 32'h6, 32'hFFFF_FFF0);
    chk("R4 wrap above top", br_target, 32'h0001_FFEC);
    // R3 other opcodes with conditions that would be met
    drive(1, 6'h04, 16'h0008, 32'h9, 32'h9, 32'h0000_4000);
    chk("R3 other op", {31'd0, br_taken}, 32'd0);
    chk("R3 other op next_pc", next_pc, 32'h0000_4000);
    drive(0, 6'h15, 16'h0008, 32'h9, 32'hA, 32'h0000_4000);
    chk("R3 bubble", {31'd0, pc_sel}, 32'd0);

    // R6 back-to-back: branch at 0x100 taken to 0x200, delay-slot branch at 0x104
    drive(1, 6'h14, 16'h003F, 32'h3, 32'h3, 32'h0000_0104);
    chk("R6 first next_pc", next_pc, 32'h0000_0200);
    drive(1, 6'h15, 16'hFFF0, 32'h3, 32'h3, 32'h0000_0108);
    chk("R6 second not taken", next_pc, 32'h0000_0108);
    drive(1, 6'h15, 16'hFFF0, 32'h3, 32'h4, 32'h0000_0108);
    chk("R6 second taken", next_pc, 32'h0000_00C8);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      a = $urandom();
      b = ($urandom() % 2 == 0) ? a : $urandom();
      case ($urandom() % 4)
        0: op = 6'h14;
        1: op = 6'h15;
        default: op = 6'($urandom());
      endcase
      drive(1'($urandom() % 8 != 0), op, 16'($urandom()), a, b, {$urandom()} & 32'hFFFF_FFFC);
      check_all(op == 6'h14 ? "R1" : (op == 6'h15 ? "R2" : "R3"));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule